// File: doc/BRIEF.md
# Register-Access Exit Filter

This block decides whether a guest's access to a model-specific register must leave the guest. A request carries a 32-bit register index, a read/write flag and a 64-bit base address for a permission bitmap in memory. Three separate index windows share this bitmap. Each register owns two adjacent bits in it: the even bit governs reads and the odd bit governs writes. The block maps the index into its window and works out the byte address and the bit inside that byte. It fetches that one byte over a simple request/response memory port and reports whether the access must exit.

An index that lies in none of the windows always exits, and no memory access is made for it. One request is handled at a time. `busy` shows that the block is occupied, and a one-cycle `done` pulse carries the verdict together with the direction of the access. The caller is expected to have already established that register accesses are intercepted at all.

Top module: `msr_exit_filter`

## Requirements
- R1: While reset is held and right after it, `busy`, `done` and `mem_req_valid` are all low.
- R2: An index in 0x0000–0x1FFF reads the byte at `base + index/4`.
- R3: An index in 0xC0000000–0xC0001FFF reads the byte at `base + 0x800 + (index − 0xC0000000)/4`.
- R4: An index in 0xC0010000–0xC0011FFF reads the byte at `base + 0x1000 + (index − 0xC0010000)/4`.
- R5: Within the fetched byte the tested bit is `2·(offset mod 4) + rw`, where offset is the index's distance from its window start and rw is 0 for a read and 1 for a write. Reads therefore test even bits and writes odd bits.
- R6: An index outside all three windows produces `done` with `done_exit`=1 in the cycle after acceptance, and no memory request is issued.
- R7: A tested bit of 1 gives `done_exit`=1, and a tested bit of 0 gives `done_exit`=0.
- R8: `done` is high for exactly one cycle per accepted request, and `done_info` equals the request's rw flag during that cycle.
- R9: Exactly one memory request is issued per in-window access. `mem_req_valid` stays high, with a stable `mem_req_addr`, until `mem_req_ready` is seen.
- R10: `req_valid` is ignored while `busy` is high. The request in flight keeps its address and its rw flag.
- R11: `busy` is high from the cycle after acceptance through the `done` cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_index | input | 32 | Register index |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_base | input | 64 | Bitmap base byte address |
| busy | output | 1 | A request is in progress |
| mem_req_valid | output | 1 | Single-byte read request |
| mem_req_addr | output | 64 | Byte address of the read |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 8 | Returned byte |
| done | output | 1 | One-cycle result pulse |
| done_exit | output | 1 | 1 when the access must exit (valid with done) |
| done_info | output | 1 | Exit information, equal to the rw flag (valid with done) |

## Verification
The bench builds the block with its default parameters: 32-bit indices, 64-bit addresses, three windows of 8192 registers, and window starts at 0, 0xC0000000 and 0xC0010000. With these values it can reach the first and last index of every window, and the indices just beside each window (0x2000, 0xBFFFFFFF, 0xC0002000, 0xC000FFFF, 0xC0012000, 0xFFFFFFFF). It can also set bitmap bytes to even-only and odd-only patterns. Memory stall and latency settings from zero to several cycles exercise the request hold and the wait for data.

// File: rtl/msrf_pkg.sv
`timescale 1ns/1ps
package msrf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ASK    = 2'd1,
    ST_WAIT   = 2'd2,
    ST_REPORT = 2'd3
  } msrf_state_e;

  // Bit inside the fetched byte: two bits per register, rw picks the odd one.
  function automatic logic [2:0] msrf_bit_in_byte(input logic [1:0] reg_in_byte,
                                                  input logic       rw);
    return {reg_in_byte, rw};
  endfunction

  // Slot count to slot-number width, never zero.
  function automatic int msrf_slot_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/msrf_locate.sv
`timescale 1ns/1ps
module msrf_locate #(
  parameter int unsigned IDX_W     = 32,
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned SPAN      = 8192,
  parameter int unsigned NUM_WIN   = 3,
  parameter logic [NUM_WIN*IDX_W-1:0] WIN_BASES = {32'hC001_0000, 32'hC000_0000, 32'h0000_0000}
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              rw,
  input  logic [ADDR_W-1:0] base,
  output logic [NUM_WIN-1:0] win_hit,
  output logic              hit,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [2:0]        bit_sel
);
  import msrf_pkg::*;

  localparam int unsigned SPAN_W  = $clog2(SPAN);
  localparam int unsigned SLOT_W  = msrf_slot_width(NUM_WIN);
  localparam int unsigned BOFF_W  = SLOT_W + SPAN_W - 2;

  logic [SPAN_W-1:0] win_rel [NUM_WIN];

  // One subtract-and-compare per window; unsigned wrap rejects indices below a start.
  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    logic [IDX_W-1:0] rel;
    assign rel        = idx - WIN_BASES[k*IDX_W +: IDX_W];
    assign win_hit[k] = (rel < IDX_W'(SPAN));
    assign win_rel[k] = rel[SPAN_W-1:0];
  end

  logic [SLOT_W-1:0] sel_slot;
  logic [SPAN_W-1:0] sel_rel;

  always_comb begin
    sel_slot = '0;
    sel_rel  = '0;
    for (int k = NUM_WIN - 1; k >= 0; k--) begin
      if (win_hit[k]) begin
        sel_slot = SLOT_W'(k);
        sel_rel  = win_rel[k];
      end
    end
  end

  logic [BOFF_W-1:0] byte_off;
  assign byte_off  = {sel_slot, sel_rel[SPAN_W-1:2]};
  assign hit       = |win_hit;
  assign byte_addr = base + ADDR_W'(byte_off);
  assign bit_sel   = msrf_bit_in_byte(sel_rel[1:0], rw);

endmodule

// File: rtl/msrf_fsm.sv
`timescale 1ns/1ps
module msrf_fsm #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hit,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [2:0]        bit_sel,
  input  logic              rw,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  output logic              evt_accept,
  output logic              busy,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              done,
  output logic              done_exit,
  output logic              done_info
);
  import msrf_pkg::*;

  msrf_state_e       state;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        bit_q;
  logic              rw_q;
  logic              exit_q;

  assign evt_accept = (state == ST_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      bit_q  <= '0;
      rw_q   <= 1'b0;
      exit_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          addr_q <= byte_addr;
          bit_q  <= bit_sel;
          rw_q   <= rw;
          if (hit) begin
            state <= ST_ASK;
          end else begin
            exit_q <= 1'b1;
            state  <= ST_REPORT;
          end
        end
        ST_ASK:  if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          exit_q <= mem_rsp_data[bit_q];
          state  <= ST_REPORT;
        end
        ST_REPORT: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_ASK);
  assign mem_req_addr  = addr_q;
  assign done          = (state == ST_REPORT);
  assign done_exit     = exit_q;
  assign done_info     = rw_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9
  AST_OOR_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && !hit) |=> (done && done_exit && !mem_req_valid)); // R6
  AST_INFO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(done_info)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !done)); // R11

endmodule

// File: rtl/msr_exit_filter.sv
`timescale 1ns/1ps
module msr_exit_filter #(
  parameter int unsigned IDX_W   = 32,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned SPAN    = 8192,
  parameter int unsigned NUM_WIN = 3,
  parameter logic [NUM_WIN*IDX_W-1:0] WIN_BASES = {32'hC001_0000, 32'hC000_0000, 32'h0000_0000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_index,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_base,
  output logic              busy,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  output logic              done,
  output logic              done_exit,
  output logic              done_info
);

  localparam int unsigned MAP_BYTES = NUM_WIN * SPAN / 4;

  logic [NUM_WIN-1:0] win_hit;
  logic               hit;
  logic [ADDR_W-1:0]  byte_addr;
  logic [2:0]         bit_sel;
  logic               evt_accept;

  msrf_locate #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .SPAN(SPAN),
    .NUM_WIN(NUM_WIN), .WIN_BASES(WIN_BASES)
  ) u_loc (
    .idx       (req_index),
    .rw        (req_write),
    .base      (req_base),
    .win_hit   (win_hit),
    .hit       (hit),
    .byte_addr (byte_addr),
    .bit_sel   (bit_sel)
  );

  msrf_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (req_valid),
    .hit           (hit),
    .byte_addr     (byte_addr),
    .bit_sel       (bit_sel),
    .rw            (req_write),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .evt_accept    (evt_accept),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .done          (done),
    .done_exit     (done_exit),
    .done_info     (done_info)
  );

  AST_WIN_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0(win_hit)); // R4
  AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_accept && hit) |-> ((byte_addr - req_base) < ADDR_W'(MAP_BYTES))); // R2
  AST_BIT_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |-> (bit_sel[0] == req_write)); // R5

endmodule

// File: tb/sim_msr_exit_filter.sv
`timescale 1ns/1ps
module sim_msr_exit_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_index = '0;
  logic        req_write = 1'b0;
  logic [63:0] req_base = '0;
  logic        mem_req_ready = 1'b1;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = '0;
  logic        busy, mem_req_valid, done, done_exit, done_info;
  logic [63:0] mem_req_addr;

  always #2 clk = ~clk;   // 250 MHz

  msr_exit_filter u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
    .req_write(req_write), .req_base(req_base), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .done_exit(done_exit),
    .done_info(done_info)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string sect = "R7";

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] bmap [logic [63:0]];
  int stall_cfg = 0, lat_cfg = 0, stall_left = 0, rsp_left = 0;
  bit rsp_pending = 0;
  logic [63:0] rsp_addr = '0;

  function automatic logic [7:0] mem_byte(logic [63:0] a);
    if (bmap.exists(a)) return bmap[a];
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  bit took, asked;
  logic [63:0] seen_addr;
  always @(posedge clk) begin
    took = mem_req_valid && mem_req_ready;
    asked = mem_req_valid;
    seen_addr = mem_req_addr;
    #1;
    mem_rsp_valid = 1'b0;
    if (!rst_n) begin
      rsp_pending = 0;
      stall_left = stall_cfg;
    end else begin
      if (took) begin
        rsp_pending = 1;
        rsp_left = lat_cfg;
        rsp_addr = seen_addr;
      end else if (rsp_pending) begin
        if (rsp_left == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = mem_byte(rsp_addr);
          rsp_pending = 0;
        end else rsp_left--;
      end
      if (!asked) stall_left = stall_cfg;
      else if (!took && stall_left > 0) stall_left--;
    end
    mem_req_ready = (stall_left == 0);
  end

  // ---------------- reference model, compared every cycle ----------------
  int ph = 0;                 // 0 free, 1 asking, 2 waiting, 3 reporting
  logic [63:0] m_addr = '0;
  int m_bit = 0;
  bit m_exit = 0, m_rw = 0;
  string m_atag = "R2", m_xtag = "R7";

  bit p_rst_n = 0, p_req_valid = 0, p_wr = 0, p_ready = 0, p_rsp_valid = 0;
  logic [31:0] p_idx = '0;
  logic [63:0] p_base = '0;
  logic [7:0]  p_data = '0;

  function automatic int window_of(logic [31:0] i, output longint off);
    off = 0;
    if (i < 32'h2000) begin off = i; return 0; end
    if (i >= 32'hC000_0000 && i <= 32'hC000_1FFF) begin off = i - 32'hC000_0000; return 1; end
    if (i >= 32'hC001_0000 && i <= 32'hC001_1FFF) begin off = i - 32'hC001_0000; return 2; end
    return -1;
  endfunction

  always @(negedge clk) begin
    if (!p_rst_n) ph = 0;
    else begin
      case (ph)
        0: if (p_req_valid) begin     // requests while busy are dropped (R10)
          longint off, pos;
          int w;
          w = window_of(p_idx, off);
          m_rw = p_wr;
          if (w < 0) begin
            ph = 3; m_exit = 1; m_xtag = "R6";
          end else begin
            pos = (longint'(w) * 8192 + off) * 2;
            m_addr = p_base + 64'(pos / 8);
            m_bit = int'(pos % 8) + (p_wr ? 1 : 0);
            m_atag = (w == 0) ? "R2" : (w == 1) ? "R3" : "R4";
            m_xtag = sect;
            ph = 1;
          end
        end
        1: if (p_ready) ph = 2;
        2: if (p_rsp_valid) begin m_exit = p_data[m_bit]; ph = 3; end
        default: ph = 0;
      endcase
    end
    if (rst_n && p_rst_n) begin
      chk("R11", "busy", 64'(busy), 64'(ph != 0));
      chk((ph == 0 && p_req_valid) ? "R6" : "R9", "mem_req_valid", 64'(mem_req_valid), 64'(ph == 1));
      if (ph == 1) chk(m_atag, "mem_req_addr", mem_req_addr, m_addr);
      chk("R8", "done", 64'(done), 64'(ph == 3));
      if (ph == 3) begin
        chk(m_xtag, "done_exit", 64'(done_exit), 64'(m_exit));
        chk("R8", "done_info", 64'(done_info), 64'(m_rw));
      end
    end
    p_rst_n = rst_n; p_req_valid = req_valid; p_wr = req_write; p_idx = req_index;
    p_base = req_base; p_ready = mem_req_ready; p_rsp_valid = mem_rsp_valid; p_data = mem_rsp_data;
  end

  // ---------------- stimulus ----------------
  task automatic access(logic [31:0] idx, bit wr, logic [63:0] base);
    @(posedge clk); #1;
    req_valid = 1; req_index = idx; req_write = wr; req_base = base;
    @(posedge clk); #1;
    req_valid = 0;
    while (!done) begin @(posedge clk); #1; end
    @(posedge clk); #1;
  endtask

  task automatic access_noisy(logic [31:0] idx, bit wr, logic [63:0] base);
    @(posedge clk); #1;
    req_valid = 1; req_index = idx; req_write = wr; req_base = base;
    @(posedge clk); #1;
    req_index = 32'h0000_0100; req_write = !wr; req_base = base + 64'h40;
    @(posedge clk); #1;
    @(posedge clk); #1;
    req_valid = 0;
    while (!done) begin @(posedge clk); #1; end
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] b;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "busy in reset", 64'(busy), 0);
    chk("R1", "done in reset", 64'(done), 0);
    chk("R1", "mem_req_valid in reset", 64'(mem_req_valid), 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    chk("R1", "busy after reset", 64'(busy), 0);
    chk("R1", "done after reset", 64'(done), 0);
    chk("R1", "mem_req_valid after reset", 64'(mem_req_valid), 0);

    b = 64'h0000_0001_2000_0000;
    sect = "R7";
    // R2 low window, edges and middle
    access(32'h0000_0000, 0, b);
    access(32'h0000_0005, 1, b);
    access(32'h0000_1FFF, 0, b);
    access(32'h0000_1FFF, 1, b);
    // R3 second window
    access(32'hC000_0000, 1, b);
    access(32'hC000_1FFF, 0, b);
    access(32'hC000_0123, 1, b);
    // R4 third window
    access(32'hC001_0000, 0, b);
    access(32'hC001_1FFF, 1, b);
    access(32'hC001_0ABC, 0, b);
    // R6 neighbours of every window
    access(32'h0000_2000, 0, b);
    access(32'hBFFF_FFFF, 1, b);
    access(32'hC000_2000, 0, b);
    access(32'hC000_FFFF, 1, b);
    access(32'hC001_2000, 0, b);
    access(32'hFFFF_FFFF, 1, b);
    // R5 even bits set: reads exit, writes allowed; then the reverse
    sect = "R5";
    bmap[b + 64'h10] = 8'h55;
    for (int i = 0; i < 4; i++) begin
      access(32'h40 + 32'(i), 0, b);
      access(32'h40 + 32'(i), 1, b);
    end
    bmap[b + 64'h10] = 8'hAA;
    for (int i = 0; i < 4; i++) begin
      access(32'h40 + 32'(i), 0, b);
      access(32'h40 + 32'(i), 1, b);
    end
    // R7 all clear / all set in the upper windows
    sect = "R7";
    bmap[b + 64'h800] = 8'h00;
    bmap[b + 64'h1000] = 8'hFF;
    access(32'hC000_0002, 1, b);
    access(32'hC001_0003, 0, b);
    // R9 stalls and latency
    stall_cfg = 3; lat_cfg = 2;
    repeat (2) @(posedge clk);
    access(32'h0000_0777, 1, b + 64'h3);
    access(32'hC001_1000, 0, b);
    stall_cfg = 1; lat_cfg = 5;
    repeat (2) @(posedge clk);
    access(32'hC000_1ABC, 1, b);
    // R10 requests while busy are ignored
    stall_cfg = 4; lat_cfg = 1;
    repeat (2) @(posedge clk);
    access_noisy(32'hC000_0999, 1, b);
    access_noisy(32'h0000_2345, 0, b);
    // mixed random traffic
    stall_cfg = 0; lat_cfg = 0;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 60; i++) begin
      logic [31:0] ix;
      case ($urandom % 4)
        0: ix = $urandom % 32'h2000;
        1: ix = 32'hC000_0000 + ($urandom % 32'h2000);
        2: ix = 32'hC001_0000 + ($urandom % 32'h2000);
        default: ix = $urandom;
      endcase
      if (i % 7 == 3) begin stall_cfg = i % 3; lat_cfg = i % 4; end
      access(ix, 1'($urandom % 2), {32'h0000_0003, $urandom} & ~64'hFFF);
    end
    repeat (5) @(posedge clk);
    summary();
    $finish;
  end

endmodule